// File: doc/BRIEF.md
# Attribute Controller Register Port

This block is the register side of a display attribute controller. Software reaches it through one 8-bit I/O address. Each write to that address goes either to the index register or to the register that the index selects. An internal phase flip-flop decides which, and every write there flips it. A second address reads back the selected register and leaves the phase alone. Reading the status address has a side effect: it returns the phase to index. A driver therefore reads status first, and its next write to the port is then known to be an index.

The block holds 21 byte-wide attribute registers. The mode register at index 0x10 is decoded into two control outputs: one selects graphics mode and one selects 8-bit pixel clocking. The status byte shows a vertical-retrace input and a display-disable input. The bus is a plain synchronous strobe interface. Read data is registered.

Top module: `attr_port`

## Requirements
- R1: After reset the port is in index phase, the index is 0x00, all 21 registers hold 0x00, `ioRdata` is 0x00, and both mode outputs are low.
- R2: A write to 0x3C0 in index phase latches the byte as the index. The next write to 0x3C0, made in data phase, stores its byte in the register that the index selects.
- R3: Every write to 0x3C0 toggles the phase. Reads of 0x3C0 and 0x3C1 leave the phase unchanged.
- R4: A read of 0x3DA returns the port to index phase, whatever phase it was in.
- R5: A read of 0x3DA returns a byte with bit 3 equal to `vRetrace` and bit 0 equal to `dispOff` in the read cycle. All other bits are zero.
- R6: An index of 0x15 or above selects no register. A data write with such an index changes no register and no output, and a read of 0x3C1 with such an index returns 0x00.
- R7: `gfxMode` equals bit 0 and `pix8Bit` equals bit 6 of the register at index 0x10. Both change in the cycle after the data write and at no other time.
- R8: Read data appears on `ioRdata` in the cycle after a cycle with `ioRd` high, and holds while `ioRd` is low. A read of any address other than 0x3C1 or 0x3DA returns 0x00.
- R9: The 21 registers are independent: a data write changes only the selected register, and a read of 0x3C1 returns the selected register's stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address |
| ioWr | input | 1 | Write strobe |
| ioRd | input | 1 | Read strobe |
| ioWdata | input | 8 | Write data |
| ioRdata | output | 8 | Registered read data |
| vRetrace | input | 1 | Vertical retrace in progress |
| dispOff | input | 1 | Display disabled / blanking |
| gfxMode | output | 1 | Decoded graphics-mode select |
| pix8Bit | output | 1 | Decoded 8-bit pixel clocking select |

## Verification
The bench builds the block with its default parameters: 21 registers, the mode register at 0x10, and the usual port addresses. This puts the boundary between the last real index (0x14) and the first empty one (0x15) in reach, along with a wide index of 0xFF. The bench fills every register with a distinct byte and reads each one back. It interleaves reads of the index, readback and status addresses with writes, so that both phase preservation and phase resynchronization show up in which register a later data byte reaches.

// File: rtl/attr_port_pkg.sv
package attr_port_pkg;

  typedef enum logic {
    PH_INDEX = 1'b0,
    PH_DATA  = 1'b1
  } attr_phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic idxLoad;
    logic dataStore;
    logic dataRead;
    logic statRead;
    logic rdAny;
  } attr_strobe_t;

endpackage

// File: rtl/attr_port_ctl.sv
module attr_port_ctl
  import attr_port_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h03C0,
  parameter logic [ADDR_W-1:0] RDBK_ADDR = 16'h03C1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h03DA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  output attr_strobe_t      strb,
  output logic              dataPhase
);

  attr_phase_e phaseQ;
  logic hitPort, hitRdbk, hitStat;

  assign hitPort = (ioAddr == PORT_ADDR);
  assign hitRdbk = (ioAddr == RDBK_ADDR);
  assign hitStat = (ioAddr == STAT_ADDR);

  always_comb begin
    strb.idxLoad   = ioWr && hitPort && (phaseQ == PH_INDEX);
    strb.dataStore = ioWr && hitPort && (phaseQ == PH_DATA);
    strb.dataRead  = ioRd && hitRdbk;
    strb.statRead  = ioRd && hitStat;
    strb.rdAny     = ioRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_INDEX;
    end else if (strb.statRead) begin
      phaseQ <= PH_INDEX;
    end else if (ioWr && hitPort) begin
      phaseQ <= (phaseQ == PH_INDEX) ? PH_DATA : PH_INDEX;
    end
  end

  assign dataPhase = (phaseQ == PH_DATA);

endmodule

// File: rtl/attr_port_dp.sv
module attr_port_dp
  import attr_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_REGS    = 21,
  parameter int unsigned MODE_IDX    = 16,
  parameter int unsigned GFX_BIT     = 0,
  parameter int unsigned PIX_BIT     = 6,
  parameter int unsigned RETRACE_BIT = 3,
  parameter int unsigned DISP_BIT    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  attr_strobe_t      strb,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic              vRetrace,
  input  logic              dispOff,
  output logic [DATA_W-1:0] ioRdata,
  output logic              gfxMode,
  output logic              pix8Bit
);

  localparam int unsigned IDX_W = DATA_W;

  logic [IDX_W-1:0]  idxQ;
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] selData;
  logic [DATA_W-1:0] statByte;

  always_ff @(posedge clk) begin
    if (!rstN)             idxQ <= '0;
    else if (strb.idxLoad) idxQ <= ioWdata;
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        regQ[gi] <= '0;
      end else if (strb.dataStore && (idxQ == IDX_W'(gi))) begin
        regQ[gi] <= ioWdata;
      end
    end
  end

  // an index past the last register matches nothing, so selData stays zero
  always_comb begin
    selData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idxQ == IDX_W'(i)) selData = selData | regQ[i];
    end
  end

  always_comb begin
    statByte = '0;
    statByte[RETRACE_BIT] = vRetrace;
    statByte[DISP_BIT]    = dispOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioRdata <= '0;
    end else if (strb.rdAny) begin
      if (strb.dataRead)      ioRdata <= selData;
      else if (strb.statRead) ioRdata <= statByte;
      else                    ioRdata <= '0;
    end
  end

  assign gfxMode = regQ[MODE_IDX][GFX_BIT];
  assign pix8Bit = regQ[MODE_IDX][PIX_BIT];

endmodule

// File: rtl/attr_port.sv
module attr_port
  import attr_port_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_REGS    = 21,
  parameter int unsigned MODE_IDX    = 16,
  parameter int unsigned GFX_BIT     = 0,
  parameter int unsigned PIX_BIT     = 6,
  parameter int unsigned RETRACE_BIT = 3,
  parameter int unsigned DISP_BIT    = 0,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h03C0,
  parameter logic [ADDR_W-1:0] RDBK_ADDR = 16'h03C1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h03DA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  input  logic              vRetrace,
  input  logic              dispOff,
  output logic              gfxMode,
  output logic              pix8Bit
);

  attr_strobe_t strb;
  logic         dataPhase;

  attr_port_ctl #(
    .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR),
    .RDBK_ADDR(RDBK_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .strb(strb), .dataPhase(dataPhase)
  );

  attr_port_dp #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .MODE_IDX(MODE_IDX),
    .GFX_BIT(GFX_BIT), .PIX_BIT(PIX_BIT),
    .RETRACE_BIT(RETRACE_BIT), .DISP_BIT(DISP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWdata(ioWdata),
    .vRetrace(vRetrace), .dispOff(dispOff), .ioRdata(ioRdata),
    .gfxMode(gfxMode), .pix8Bit(pix8Bit)
  );

endmodule

// File: rtl/attr_port_chk.sv
module attr_port_chk #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned RETRACE_BIT = 3,
  parameter int unsigned DISP_BIT    = 0,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h03C0,
  parameter logic [ADDR_W-1:0] RDBK_ADDR = 16'h03C1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h03DA
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioRdata,
  input logic              vRetrace,
  input logic              dispOff,
  input logic              gfxMode,
  input logic              pix8Bit,
  input logic              dataPhase
);

  logic portWr, statRd;
  assign portWr = ioWr && (ioAddr == PORT_ADDR);
  assign statRd = ioRd && (ioAddr == STAT_ADDR);

  assert_port_toggle_R3: assert property (@(posedge clk) disable iff (!rstN)
    portWr && !statRd |=> dataPhase != $past(dataPhase));

  assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !portWr && !statRd |=> $stable(dataPhase));

  assert_status_resync_R4: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> !dataPhase);

  assert_status_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> (ioRdata[RETRACE_BIT] == $past(vRetrace)) &&
               (ioRdata[DISP_BIT] == $past(dispOff)) &&
               ($countones(ioRdata) == $countones({$past(vRetrace), $past(dispOff)})));

  assert_mode_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(portWr && dataPhase) |=> $stable(gfxMode) && $stable(pix8Bit));

  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ioRd |=> $stable(ioRdata));

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    ioRd && (ioAddr != RDBK_ADDR) && (ioAddr != STAT_ADDR) |=> ioRdata == '0);

endmodule

bind attr_port attr_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .RETRACE_BIT(RETRACE_BIT), .DISP_BIT(DISP_BIT),
  .PORT_ADDR(PORT_ADDR), .RDBK_ADDR(RDBK_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
  .ioRdata(ioRdata), .vRetrace(vRetrace), .dispOff(dispOff),
  .gfxMode(gfxMode), .pix8Bit(pix8Bit), .dataPhase(dataPhase)
);

// File: tb/test_attr_port.sv
`timescale 1ns/1ps
module test_attr_port;

  localparam int NREG = 21;
  localparam logic [15:0] A_PORT = 16'h03C0;
  localparam logic [15:0] A_RDBK = 16'h03C1;
  localparam logic [15:0] A_STAT = 16'h03DA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic ioWr = 1'b0, ioRd = 1'b0;
  logic [7:0] ioWdata = '0;
  logic [7:0] ioRdata;
  logic vRetrace = 1'b0, dispOff = 1'b0;
  logic gfxMode, pix8Bit;

  always #2 clk = ~clk;

  attr_port i_attr_port (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .vRetrace(vRetrace),
    .dispOff(dispOff), .gfxMode(gfxMode), .pix8Bit(pix8Bit)
  );

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t scb[$];

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // requirement-level model of the port
  logic [7:0] mReg [NREG];
  logic [7:0] mIdx;
  bit         mPhase;

  task automatic compare(input logic [7:0] act, input logic [7:0] expv, input string tag);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, expv);
    end
  endtask

  // monitor: read data is due one cycle after the strobe
  always @(posedge clk) begin
    if (ioRd && rstN) begin
      #1;
      if (scb.size() == 0) begin
        compare(ioRdata, 8'hxx, "R8 unexpected read");
      end else begin
        exp_t e;
        e = scb.pop_front();
        compare(ioRdata, e.val, e.tag);
      end
    end
  end

  task automatic busWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
    if (a == A_PORT) begin
      if (!mPhase) mIdx = d;
      else if (mIdx < NREG) mReg[mIdx] = d;
      mPhase = !mPhase;
    end
  endtask

  task automatic portWr(input logic [7:0] d);
    busWr(A_PORT, d);
  endtask

  task automatic busRd(input logic [15:0] a, input string tag);
    exp_t e;
    e.tag = tag;
    if (a == A_RDBK)      e.val = (mIdx < NREG) ? mReg[mIdx] : 8'h00;
    else if (a == A_STAT) e.val = {4'b0, vRetrace, 2'b0, dispOff};
    else                  e.val = 8'h00;
    scb.push_back(e);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    @(negedge clk);
    ioRd = 1'b0;
    if (a == A_STAT) mPhase = 1'b0;
  endtask

  task automatic chkMode(input string tag);
    compare({6'b0, gfxMode, pix8Bit}, {6'b0, mReg[16][0], mReg[16][6]}, tag);
  endtask

  // read register r back through the port, then resync
  task automatic readBack(input int r, input string tag);
    busRd(A_STAT, "R4 resync before readback");
    portWr(8'(r));
    busRd(A_RDBK, tag);
    busRd(A_STAT, "R4 resync after readback");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mReg[i] = '0;
    mIdx = '0; mPhase = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    compare(ioRdata, 8'h00, "R1 rdata after reset");
    chkMode("R1 mode outputs after reset");
    busRd(A_RDBK, "R1 reg 0 after reset");
    portWr(8'h14);
    busRd(A_RDBK, "R1 reg 0x14 after reset");
    busRd(A_STAT, "R4 status resync");

    // R2 / R7 mode register
    portWr(8'h10); portWr(8'h41);
    chkMode("R7 mode 0x41");
    busRd(A_RDBK, "R2 readback 0x10");
    portWr(8'h10); portWr(8'h40);
    chkMode("R7 mode 0x40");
    portWr(8'h10); portWr(8'h01);
    chkMode("R7 mode 0x01");
    portWr(8'h10); portWr(8'hBE);
    chkMode("R7 mode 0xBE other bits");

    // R9 fill every register then read each back
    for (int i = 0; i < NREG; i++) begin
      portWr(8'(i)); portWr(8'(i * 11 + 3));
    end
    chkMode("R7 mode after fill");
    for (int i = 0; i < NREG; i++) readBack(i, $sformatf("R9 reg %0d", i));

    // R3 reads leave phase alone
    portWr(8'h05);
    busRd(A_PORT, "R8 read of port address is zero");
    busRd(A_RDBK, "R3 readback in data phase");
    portWr(8'h77);
    readBack(5, "R3 data reached reg 5 after reads");

    // R4 status read resyncs mid-sequence
    portWr(8'h06);
    busRd(A_STAT, "R4 resync from data phase");
    portWr(8'h07); portWr(8'h99);
    readBack(7, "R4 byte landed in reg 7");
    readBack(6, "R4 reg 6 untouched");

    // R5 status bits
    vRetrace = 1'b1; dispOff = 1'b0;
    busRd(A_STAT, "R5 retrace only");
    vRetrace = 1'b1; dispOff = 1'b1;
    busRd(A_STAT, "R5 both set");
    vRetrace = 1'b0; dispOff = 1'b1;
    busRd(A_STAT, "R5 display off only");
    vRetrace = 1'b0; dispOff = 1'b0;

    // R6 out-of-range index
    portWr(8'h15); portWr(8'hFF);
    portWr(8'h15);
    busRd(A_RDBK, "R6 index 0x15 reads zero");
    busRd(A_STAT, "R4 resync");
    portWr(8'hFF); portWr(8'h55);
    portWr(8'hFF);
    busRd(A_RDBK, "R6 index 0xFF reads zero");
    chkMode("R6 mode outputs unchanged");
    readBack(20, "R6 reg 0x14 unchanged");
    readBack(0, "R6 reg 0 unchanged");

    // R8 unmapped address
    busRd(16'h03C2, "R8 unmapped read zero");
    busWr(16'h03C2, 8'hAA);
    readBack(1, "R8 unmapped write ignored");

    repeat (4) @(negedge clk);
    if (scb.size() != 0) compare(8'(scb.size()), 8'h00, "R8 reads left unanswered");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule